// File: doc/BRIEF.md
# Serial Byte Receiver with Parity Check and Receive Queue

This block turns an asynchronous serial input line into bytes. The line is first brought into the clock domain by a two-stage synchroniser. A falling edge on an idle line opens a frame, and the start bit is confirmed low at its centre. Eight data bits are then sampled at their centres, least significant bit first. An optional parity bit follows, then one or two stop bits. Each received byte enters a 16-entry first-in first-out queue.

Software-facing logic reads the queue through a head byte, an empty flag and a pop strobe. A flush strobe can discard the queue's contents. The bit period is set by a 16-bit divisor: one bit lasts divisor+1 clocks. Parity can be off, odd or even. A parity mismatch is reported as a one-clock pulse, and the byte is still kept.

Top module: `srx_top`

## Requirements
- R1: One bit period is divisor_i+1 clock cycles. A frame begins on a falling edge of the synchronised line. The start bit is re-sampled (divisor_i>>1) cycles later, and each following sample comes divisor_i+1 cycles after the previous one.
- R2: If the line is high again when the start bit is re-sampled, the frame is abandoned and nothing is stored.
- R3: Each frame carries eight data bits, least significant bit first, and they are assembled into one byte.
- R4: parity_sel_i selects the parity bit. 0 means no parity bit, 1 means odd parity (data ones plus the parity bit is odd) and 2 means even parity. Value 3 is unsupported. With parity off, parity_err_o never pulses.
- R5: When the received parity bit does not match the selected parity, parity_err_o is high for exactly one cycle as the byte is stored. The byte still enters the queue.
- R6: two_stop_i=0 expects one stop bit and two_stop_i=1 expects two. Back-to-back frames with the configured number of stop bits are all received.
- R7: empty_o is 1 exactly when the queue holds no byte. While it is 0, head_o shows the oldest stored byte.
- R8: pop_i removes the head byte. A pop while empty has no effect.
- R9: The queue holds 16 bytes. A byte that completes while the queue is full is dropped, and the stored bytes and their order are unchanged.
- R10: flush_i empties the queue in one cycle. It takes priority over a byte completing in the same cycle.
- R11: After reset the queue is empty, parity_err_o is 0 and the receiver waits for a start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial input, idle high |
| divisor_i | input | 16 | Bit period minus one, in clocks |
| parity_sel_i | input | 2 | 0 none, 1 odd, 2 even |
| two_stop_i | input | 1 | 1 selects two stop bits |
| flush_i | input | 1 | Discard all queued bytes |
| pop_i | input | 1 | Remove the head byte |
| head_o | output | 8 | Oldest queued byte |
| empty_o | output | 1 | Queue holds no byte |
| parity_err_o | output | 1 | One-cycle parity mismatch pulse |

## Verification
Frames are sent with two different divisors, one even and one odd. Only a receiver that uses the correct divisor+1 bit period and the correct half-bit offset recovers those bytes, which tests R1. The bytes 0x01 and 0x80 are sent to tell least-significant-first order from the reverse. Each parity mode is tried with both correct and inverted parity bits, so a mismatch pulse that still stores the byte is distinguished from a dropped byte or a missed error.

A short low glitch checks that an unconfirmed start leaves the queue empty. A seventeen-frame burst checks that the overflow byte is dropped while the sixteen earlier bytes come out in order. Flush and pop-on-empty are each followed by a fresh frame, so any stray state left behind would show up on head_o.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] PAR_NONE = 2'd0;
  localparam logic [1:0] PAR_ODD  = 2'd1;
  localparam logic [1:0] PAR_EVEN = 2'd2;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_s_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic [1:0]        parity_sel_i,
  input  logic              two_stop_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              perr_o
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              perr_q, perr_d;
  logic              stop2_q, stop2_d;
  logic              prev_q;
  logic              valid_q, valid_d;
  logic              pulse_q, pulse_d;
  logic              bit_done, half_done;

  assign bit_done  = (cnt_q == divisor_i);
  assign half_done = (cnt_q == (divisor_i >> 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    bit_d   = bit_q;
    shift_d = shift_q;
    perr_d  = perr_q;
    stop2_d = stop2_q;
    valid_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (prev_q && !rx_s_i) state_d = ST_START;
      end
      ST_START: begin
        if (half_done) begin
          cnt_d   = '0;
          bit_d   = '0;
          state_d = rx_s_i ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (bit_done) begin
          cnt_d   = '0;
          shift_d = {rx_s_i, shift_q[DATA_W-1:1]};
          if (bit_q == LAST_BIT) begin
            perr_d  = 1'b0;
            stop2_d = two_stop_i;
            state_d = (parity_sel_i != PAR_NONE) ? ST_PAR : ST_STOP;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (bit_done) begin
          cnt_d   = '0;
          perr_d  = ((^shift_q) ^ rx_s_i) != (parity_sel_i == PAR_ODD);
          stop2_d = two_stop_i;
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (bit_done) begin
          cnt_d = '0;
          if (stop2_q) begin
            stop2_d = 1'b0;
          end else begin
            valid_d = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    pulse_d = valid_d & perr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      perr_q  <= 1'b0;
      stop2_q <= 1'b0;
      prev_q  <= 1'b1;
      valid_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      perr_q  <= perr_d;
      stop2_q <= stop2_d;
      prev_q  <= rx_s_i;
      valid_q <= valid_d;
      pulse_q <= pulse_d;
    end
  end

  assign byte_o       = shift_q;
  assign byte_valid_o = valid_q;
  assign perr_o       = pulse_q;
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic [CW-1:0]     count_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              full, push_en, pop_en;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_en = push_i && !full && !flush_i;
  assign pop_en  = pop_i && !empty_o && !flush_i;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_en) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_en)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (push_en && !pop_en)      cnt_d = cnt_q + 1'b1;
      else if (pop_en && !push_en) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_en) mem_q[wr_q] <= data_i;
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/srx_top.sv
module srx_top #(
  parameter int DIV_W      = 16,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic [1:0]        parity_sel_i,
  input  logic              two_stop_i,
  input  logic              flush_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              parity_err_o
);
  logic              rx_s;
  logic [DATA_W-1:0] rx_byte;
  logic              byte_valid;
  logic [CNT_W-1:0]  fifo_count;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (rx_s)
  );

  srx_frame #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_s_i       (rx_s),
    .divisor_i    (divisor_i),
    .parity_sel_i (parity_sel_i),
    .two_stop_i   (two_stop_i),
    .byte_o       (rx_byte),
    .byte_valid_o (byte_valid),
    .perr_o       (parity_err_o)
  );

  srx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (byte_valid),
    .data_i  (rx_byte),
    .pop_i   (pop_i),
    .head_o  (head_o),
    .empty_o (empty_o),
    .count_o (fifo_count)
  );
endmodule

// File: rtl/srx_checks.sv
module srx_checks #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          flush_i,
  input logic          pop_i,
  input logic [1:0]    parity_sel_i,
  input logic          empty_o,
  input logic          parity_err_o,
  input logic          byte_valid,
  input logic [CW-1:0] fifo_count
);
  a_r10_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);

  a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_count <= CW'(DEPTH));

  a_r9_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_count == CW'(DEPTH) && byte_valid && !pop_i && !flush_i) |=> fifo_count == CW'(DEPTH));

  a_r8_pop_empty_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !byte_valid) |=> empty_o);

  a_r5_perr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_o |=> !parity_err_o);

  a_r4_no_perr_unless_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_o |-> parity_sel_i != 2'd0);

  a_r7_store_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid && !flush_i && fifo_count < CW'(DEPTH)) |=> !empty_o);
endmodule

bind srx_top srx_checks #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .pop_i        (pop_i),
  .parity_sel_i (parity_sel_i),
  .empty_o      (empty_o),
  .parity_err_o (parity_err_o),
  .byte_valid   (byte_valid),
  .fifo_count   (fifo_count)
);

// File: tb/srx_top_tb_top.sv
module srx_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        rx_i;
  logic [15:0] divisor_i;
  logic [1:0]  parity_sel_i;
  logic        two_stop_i;
  logic        flush_i;
  logic        pop_i;
  logic [7:0]  head_o;
  logic        empty_o;
  logic        parity_err_o;

  int n_checks = 0;
  int n_fail   = 0;
  int perr_cnt = 0;
  bit done     = 1'b0;

  always #2 clk_i = ~clk_i;

  srx_top dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_i         (rx_i),
    .divisor_i    (divisor_i),
    .parity_sel_i (parity_sel_i),
    .two_stop_i   (two_stop_i),
    .flush_i      (flush_i),
    .pop_i        (pop_i),
    .head_o       (head_o),
    .empty_o      (empty_o),
    .parity_err_o (parity_err_o)
  );

  always @(negedge clk_i) if (parity_err_o) perr_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic drive_bit(input logic v);
    rx_i = v;
    repeat (int'(divisor_i) + 1) @(negedge clk_i);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit corrupt);
    logic pb;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (parity_sel_i != 2'd0) begin
      pb = (^d) ^ (parity_sel_i == 2'd1) ^ corrupt;
      drive_bit(pb);
    end
    drive_bit(1'b1);
    if (two_stop_i) drive_bit(1'b1);
  endtask

  task automatic pop_one();
    pop_i = 1'b1;
    @(negedge clk_i);
    pop_i = 1'b0;
  endtask

  task automatic expect_head(input string req, input logic [7:0] exp);
    repeat (4) @(negedge clk_i);
    chk({req, " not empty"}, empty_o, 1'b0);
    chk({req, " head"}, head_o, exp);
    pop_one();
  endtask

  task automatic configure(input int div, input logic [1:0] ps, input logic ts);
    divisor_i = 16'(div);
    parity_sel_i = ps;
    two_stop_i = ts;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R11 empty after reset", empty_o, 1'b1);
    chk("R11 no parity pulse", parity_err_o, 1'b0);
  endtask

  task automatic t_timing();
    configure(7, 2'd0, 1'b0);
    send_frame(8'hA5, 0);
    expect_head("R1 div7", 8'hA5);
    configure(10, 2'd0, 1'b0);
    send_frame(8'h3C, 0);
    expect_head("R1 div10", 8'h3C);
  endtask

  task automatic t_order();
    configure(6, 2'd0, 1'b0);
    send_frame(8'h01, 0);
    expect_head("R3 lsb first 01", 8'h01);
    send_frame(8'h80, 0);
    expect_head("R3 lsb first 80", 8'h80);
  endtask

  task automatic t_parity();
    int base;
    configure(6, 2'd1, 1'b0);
    base = perr_cnt;
    send_frame(8'h07, 0);
    expect_head("R4 odd good", 8'h07);
    chk("R4 odd good no pulse", perr_cnt - base, 0);
    base = perr_cnt;
    send_frame(8'h55, 1);
    expect_head("R5 odd bad kept", 8'h55);
    chk("R5 odd bad pulse", perr_cnt - base, 1);
    configure(6, 2'd2, 1'b0);
    base = perr_cnt;
    send_frame(8'h03, 0);
    expect_head("R4 even good", 8'h03);
    chk("R4 even good no pulse", perr_cnt - base, 0);
    base = perr_cnt;
    send_frame(8'h0F, 1);
    expect_head("R5 even bad kept", 8'h0F);
    chk("R5 even bad pulse", perr_cnt - base, 1);
    configure(6, 2'd0, 1'b0);
    base = perr_cnt;
    send_frame(8'hFE, 0);
    expect_head("R4 none", 8'hFE);
    chk("R4 none no pulse", perr_cnt - base, 0);
  endtask

  task automatic t_two_stop();
    configure(6, 2'd2, 1'b1);
    send_frame(8'h12, 0);
    send_frame(8'h34, 0);
    expect_head("R6 two stop first", 8'h12);
    expect_head("R6 two stop second", 8'h34);
    chk("R6 drained", empty_o, 1'b1);
  endtask

  task automatic t_glitch();
    configure(9, 2'd0, 1'b0);
    rx_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rx_i = 1'b1;
    repeat (40) @(negedge clk_i);
    chk("R2 glitch ignored", empty_o, 1'b1);
    send_frame(8'hC3, 0);
    expect_head("R2 next frame ok", 8'hC3);
  endtask

  task automatic t_fifo_order();
    configure(5, 2'd0, 1'b0);
    send_frame(8'h11, 0);
    send_frame(8'h22, 0);
    send_frame(8'h33, 0);
    expect_head("R7 order 1", 8'h11);
    expect_head("R7 order 2", 8'h22);
    expect_head("R7 order 3", 8'h33);
    chk("R7 empty after drain", empty_o, 1'b1);
  endtask

  task automatic t_pop_empty();
    configure(5, 2'd0, 1'b0);
    pop_one();
    pop_one();
    chk("R8 still empty", empty_o, 1'b1);
    send_frame(8'h5A, 0);
    expect_head("R8 after empty pops", 8'h5A);
    chk("R8 single byte", empty_o, 1'b1);
  endtask

  task automatic t_full();
    configure(5, 2'd0, 1'b0);
    for (int i = 0; i < 17; i++) send_frame(8'(8'h40 + i), 0);
    for (int i = 0; i < 16; i++) expect_head("R9 full order", 8'(8'h40 + i));
    chk("R9 overflow dropped", empty_o, 1'b1);
  endtask

  task automatic t_flush();
    configure(5, 2'd0, 1'b0);
    send_frame(8'hAA, 0);
    send_frame(8'hBB, 0);
    repeat (4) @(negedge clk_i);
    chk("R10 filled", empty_o, 1'b0);
    flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
    chk("R10 flushed", empty_o, 1'b1);
    send_frame(8'hCD, 0);
    expect_head("R10 after flush", 8'hCD);
    chk("R10 only new byte", empty_o, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    rst_ni = 1'b0;
    rx_i = 1'b1;
    divisor_i = 16'd7;
    parity_sel_i = 2'd0;
    two_stop_i = 1'b0;
    flush_i = 1'b0;
    pop_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_timing();
    t_order();
    t_parity();
    t_two_stop();
    t_glitch();
    t_fifo_order();
    t_pop_empty();
    t_full();
    t_flush();
    repeat (10) @(negedge clk_i);
    summary();
  end
endmodule